// File: doc/BRIEF.md
# Page-mode parallel ROM reader

This block sits between a synchronous request port and an asynchronous 32-Mbit parallel ROM that can be read as 16-bit words or as 8-bit bytes. A client presents a byte address and a width flag on a valid/ready handshake. The controller drives the ROM's select, read-enable, width and word-address pins, waits a set number of clock cycles, samples the data bus and returns the result as a one-cycle response pulse.

The ROM opens a page of eight words on its first access. Later reads inside that page settle much faster. The controller keeps track of the open page. When a request hits the open page, it uses the short page wait and skips the setup cycle. In byte mode the ROM's top data line becomes an extra address input. The controller then drives the byte-select bit on that line itself, and it never drives the line while the ROM could be driving it. After a programmable number of idle cycles the controller deselects the ROM, which lets the ROM drop to standby, and releases that line.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, rom_sel_n and rom_rd_n are high, rom_top_oe and rsp_valid are low, and req_ready is high.
- R2: When req_byte is 0 (word mode), rom_wide is 1 and rsp_data holds the full 16-bit word at word address req_addr[WORD_AW:1]. req_addr[0] has no effect.
- R3: When req_byte is 1 (byte mode), rom_wide is 0, rom_top_o equals req_addr[0], and rom_top_oe is 1. rsp_data[7:0] holds bus bits 7:0 and rsp_data[15:8] is zero.
- R4: A page miss has one setup cycle with rom_sel_n low and rom_rd_n high, followed by T_RAND cycles with rom_rd_n low. rsp_valid is seen T_RAND+1 clock edges after the accepting edge.
- R5: A request is a page hit when rom_sel_n has stayed low since the previous access, the page bits req_addr[WORD_AW:PAGE_BITS+1] match, and the mode matches. A hit skips the setup cycle, and rsp_valid is seen T_PAGE edges after the accepting edge.
- R6: A request whose mode differs from the open page's mode is handled as a miss, even if its page bits match.
- R7: When no request is accepted, rom_sel_n rises exactly IDLE_TO clock edges after the response edge. The next access after that is a miss.
- R8: rom_top_oe is high only while rom_wide is low, and it rises only while rom_rd_n is high. It is never high while the ROM drives a full word, and it is low in standby.
- R9: req_ready is high only while the controller is idle. Each accepted request gives exactly one rsp_valid pulse, and rom_rd_n is low only while rom_sel_n is low.
- R10: rom_rd_n is high in the cycle in which rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | WORD_AW+1 | Byte address; bit 0 selects the byte in byte mode |
| req_byte | input | 1 | 1 selects byte mode, 0 selects word mode |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 16 | Read data; upper half zero in byte mode |
| rom_sel_n | output | 1 | ROM select, active low |
| rom_rd_n | output | 1 | ROM output enable, active low |
| rom_wide | output | 1 | ROM width pin: 1 word, 0 byte |
| rom_addr | output | WORD_AW | ROM word address |
| rom_top_o | output | 1 | Byte-select bit driven on the ROM's top data line |
| rom_top_oe | output | 1 | Controller drives the top data line |
| rom_dq_in | input | 16 | ROM data bus as seen by the controller |

## Verification
The assertions assume that req_valid stays low during reset. They also assume that the ROM releases its top data line whenever the width pin is low or the read enable is high. The bench's ROM model behaves this way, so contention can only come from the controller side. The bench raises req_valid only on a falling edge where req_ready is already high and holds it for exactly one rising edge, so every request is accepted on the first edge. The ROM model returns wrong data until the access and page times have passed, so a wait that is too short shows up as a data mismatch.

// File: rtl/prom_pkg.sv
package prom_pkg;

    localparam int DATA_W = 16;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } rd_state_e;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_BYTE = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic             valid;
        logic [DATA_W-1:0] data;
    } rd_rsp_t;

    function automatic logic [DATA_W-1:0] steer_bus(input bus_mode_e m,
                                                    input logic [DATA_W-1:0] b);
        if (m == MODE_BYTE)
            return {{(DATA_W-LANE_W){1'b0}}, b[LANE_W-1:0]};
        return b;
    endfunction

endpackage

// File: rtl/prom_countdown.sv
module prom_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = busy_q && (cnt_q == '0);
endmodule

// File: rtl/prom_page_track.sv
module prom_page_track
    import prom_pkg::*;
#(
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_pg,
    input  logic             close_pg,
    input  logic [TAG_W-1:0] tag,
    input  bus_mode_e        mode,
    output logic             hit
);
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    bus_mode_e        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            mode_q  <= MODE_WORD;
        end else if (open_pg) begin
            valid_q <= 1'b1;
            tag_q   <= tag;
            mode_q  <= mode;
        end else if (close_pg) begin
            valid_q <= 1'b0;
        end
    end

    assign hit = valid_q && (tag_q == tag) && (mode_q == mode);
endmodule

// File: rtl/prom_data_steer.sv
module prom_data_steer
    import prom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  bus_mode_e         mode,
    input  logic [DATA_W-1:0] bus,
    output rd_rsp_t           rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= capture;
            if (capture)
                rsp.data <= steer_bus(mode, bus);
        end
    end
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
    import prom_pkg::*;
#(
    parameter int WORD_AW   = 21,
    parameter int PAGE_BITS = 3,
    parameter int T_RAND    = 10,
    parameter int T_PAGE    = 3,
    parameter int IDLE_TO   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WORD_AW:0]   req_addr,
    input  logic               req_byte,
    output logic               rsp_valid,
    output logic [15:0]        rsp_data,
    output logic               rom_sel_n,
    output logic               rom_rd_n,
    output logic               rom_wide,
    output logic [WORD_AW-1:0] rom_addr,
    output logic               rom_top_o,
    output logic               rom_top_oe,
    input  logic [15:0]        rom_dq_in
);
    localparam int TAG_W    = WORD_AW - PAGE_BITS;
    localparam int WAIT_MAX = (T_RAND > T_PAGE) ? T_RAND : T_PAGE;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int IDLE_W   = $clog2(IDLE_TO + 1);

    typedef struct packed {
        logic [WORD_AW-1:0] word;
        logic               lsb;
        bus_mode_e          mode;
    } rd_req_t;

    rd_state_e   state_q;
    bus_mode_e   mode_q;
    rd_req_t     req;
    rd_rsp_t     rsp;
    logic        accept;
    logic        page_hit;
    logic        wait_load, wait_exp;
    logic [WAIT_W-1:0] wait_val;
    logic        idle_load, idle_exp;
    logic        go_standby;
    logic        sample;

    assign req.word = req_addr[WORD_AW:1];
    assign req.lsb  = req_addr[0];
    assign req.mode = req_byte ? MODE_BYTE : MODE_WORD;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign sample     = (state_q == ST_ACCESS) && wait_exp;
    assign go_standby = (state_q == ST_IDLE) && !accept && idle_exp;

    prom_page_track #(.TAG_W(TAG_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .open_pg  (accept),
        .close_pg (go_standby),
        .tag      (req.word[WORD_AW-1:PAGE_BITS]),
        .mode     (req.mode),
        .hit      (page_hit)
    );

    always_comb begin
        wait_load = 1'b0;
        wait_val  = WAIT_W'(T_PAGE - 1);
        if (state_q == ST_SETUP) begin
            wait_load = 1'b1;
            wait_val  = WAIT_W'(T_RAND - 1);
        end else if (accept && page_hit) begin
            wait_load = 1'b1;
        end
    end

    prom_countdown #(.CNT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .clear    (1'b0),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_exp)
    );

    assign idle_load = sample;

    prom_countdown #(.CNT_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .load     (idle_load),
        .load_val (IDLE_W'(IDLE_TO - 1)),
        .expired  (idle_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_WORD;
            rom_sel_n  <= 1'b1;
            rom_rd_n   <= 1'b1;
            rom_wide   <= 1'b1;
            rom_addr   <= '0;
            rom_top_o  <= 1'b0;
            rom_top_oe <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q     <= req.mode;
                        rom_addr   <= req.word;
                        rom_top_o  <= req.lsb;
                        rom_wide   <= (req.mode == MODE_WORD);
                        rom_top_oe <= (req.mode == MODE_BYTE);
                        rom_sel_n  <= 1'b0;
                        if (page_hit) begin
                            rom_rd_n <= 1'b0;
                            state_q  <= ST_ACCESS;
                        end else begin
                            state_q  <= ST_SETUP;
                        end
                    end else if (go_standby) begin
                        rom_sel_n  <= 1'b1;
                        rom_top_oe <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    rom_rd_n <= 1'b0;
                    state_q  <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (wait_exp) begin
                        rom_rd_n <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    prom_data_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .capture (sample),
        .mode    (mode_q),
        .bus     (rom_dq_in),
        .rsp     (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_data  = rsp.data;
endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic req_byte,
    input logic rsp_valid,
    input logic rom_sel_n,
    input logic rom_rd_n,
    input logic rom_wide,
    input logic rom_top_oe
);
    // R8
    top_lane_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rom_top_oe |-> !rom_wide);

    // R8
    top_lane_take_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_top_oe) |-> rom_rd_n);

    // R8
    top_lane_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_sel_n) |-> (rom_rd_n && !rom_top_oe));

    // R9
    rd_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_rd_n |-> !rom_sel_n);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10
    rd_off_at_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rom_rd_n);

    // R4
    standby_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && rom_sel_n) |=> rom_rd_n);

    // R6
    mode_flip_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rom_sel_n && (req_byte == rom_wide)) |=> rom_rd_n);
endmodule

bind prom_page_reader prom_page_reader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_byte   (req_byte),
    .rsp_valid  (rsp_valid),
    .rom_sel_n  (rom_sel_n),
    .rom_rd_n   (rom_rd_n),
    .rom_wide   (rom_wide),
    .rom_top_oe (rom_top_oe)
);

// File: tb/sim_prom_page_reader.sv
module sim_prom_page_reader;
    localparam int CLK_PERIOD = 10;
    localparam int WA = 6;
    localparam int PB = 3;
    localparam int TR = 5;
    localparam int TP = 2;
    localparam int IT = 6;
    localparam int NBYTES = 1 << (WA + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [WA:0]   req_addr = '0;
    logic          req_byte = 1'b0;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic          rom_sel_n, rom_rd_n, rom_wide, rom_top_o, rom_top_oe;
    logic [WA-1:0] rom_addr;
    logic [15:0]   rom_dq;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    bit open_valid = 0;
    int open_pg = 0;
    bit open_bm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prom_page_reader #(
        .WORD_AW(WA), .PAGE_BITS(PB), .T_RAND(TR), .T_PAGE(TP), .IDLE_TO(IT)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_sel_n(rom_sel_n), .rom_rd_n(rom_rd_n), .rom_wide(rom_wide),
        .rom_addr(rom_addr), .rom_top_o(rom_top_o), .rom_top_oe(rom_top_oe),
        .rom_dq_in(rom_dq)
    );

    function automatic logic [15:0] word_val(input int a);
        int v;
        v = (a * 40503) ^ (a << 7) ^ 32'h5A3C;
        return v[15:0];
    endfunction

    function automatic logic [7:0] byte_val(input int ba);
        logic [15:0] w;
        w = word_val(ba >> 1);
        return ba[0] ? w[15:8] : w[7:0];
    endfunction

    // Behavioural ROM: data settles only after the page time and the access time.
    int            pg_age = 0;
    int            wd_age = 0;
    logic [WA-PB-1:0] m_pg = '0;
    logic          m_wide = 1'b1;
    logic [WA:0]   m_key = '0;
    logic [WA:0]   cur_key;

    assign cur_key = {rom_addr, rom_wide ? 1'b0 : rom_top_o};

    always @(negedge clk) begin
        if (rom_sel_n || rom_addr[WA-1:PB] != m_pg || rom_wide != m_wide)
            pg_age <= (!rom_sel_n && !rom_rd_n) ? 1 : 0;
        else if (!rom_rd_n && pg_age < 1000)
            pg_age <= pg_age + 1;
        if (rom_sel_n || rom_rd_n)
            wd_age <= 0;
        else if (cur_key != m_key)
            wd_age <= 1;
        else if (wd_age < 1000)
            wd_age <= wd_age + 1;
        m_pg   <= rom_addr[WA-1:PB];
        m_wide <= rom_wide;
        m_key  <= cur_key;
    end

    always_comb begin
        logic [15:0] good;
        if (rom_wide) good = word_val(int'(rom_addr));
        else          good = {8'hA5, byte_val(int'(cur_key))};
        if (!rom_sel_n && !rom_rd_n && pg_age >= TR && wd_age >= TP)
            rom_dq = good;
        else
            rom_dq = ~good;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // R8: the controller never drives the top line while the ROM drives a word
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(!(!rom_sel_n && !rom_rd_n && rom_wide && rom_top_oe), "R8",
                "top line contention", int'(rom_top_oe), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 200000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic do_read(input int ba, input bit bm, input int gap);
        int lat;
        bit exp_hit;
        int pg;
        string tag;
        logic [15:0] exp_d;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            // R7: standby after IDLE_TO idle edges
            if (open_valid)
                chk(rom_sel_n == (i >= IT), "R7", "select after idle", int'(rom_sel_n), int'(i >= IT));
            else
                chk(rom_sel_n == 1'b1, "R7", "select while closed", int'(rom_sel_n), 1);
            if (rom_sel_n)
                chk(rom_top_oe == 1'b0, "R8", "top line in standby", int'(rom_top_oe), 0);
        end
        if (gap >= IT) open_valid = 0;
        pg = (ba >> 1) >> PB;
        exp_hit = open_valid && (pg == open_pg) && (bm == open_bm);
        if (exp_hit)                 tag = "R5";
        else if (open_valid && pg == open_pg) tag = "R6";
        else                         tag = "R4";
        req_addr  = ba[WA:0];
        req_byte  = bm;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
        chk(rom_wide == !bm, bm ? "R3" : "R2", "width pin", int'(rom_wide), int'(!bm));
        chk(rom_top_oe == bm, "R3", "top line drive", int'(rom_top_oe), int'(bm));
        if (bm) chk(rom_top_o == ba[0], "R3", "byte select bit", int'(rom_top_o), ba & 1);
        chk(rom_rd_n == !exp_hit, tag, "read enable after accept", int'(rom_rd_n), int'(!exp_hit));
        lat = 1;
        while (!rsp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        lat = lat - 1;
        chk(lat == (exp_hit ? TP : TR + 1), tag, "latency", lat, exp_hit ? TP : TR + 1);
        exp_d = bm ? {8'h00, byte_val(ba)} : word_val(ba >> 1);
        chk(rsp_data == exp_d, bm ? "R3" : "R2", "read data", int'(rsp_data), int'(exp_d));
        chk(rom_rd_n == 1'b1, "R10", "read enable at response", int'(rom_rd_n), 1);
        open_valid = 1;
        open_pg = pg;
        open_bm = bm;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rom_sel_n == 1'b1, "R1", "select after reset", int'(rom_sel_n), 1);
        chk(rom_rd_n == 1'b1, "R1", "read enable after reset", int'(rom_rd_n), 1);
        chk(rom_top_oe == 1'b0, "R1", "top line after reset", int'(rom_top_oe), 0);
        chk(rsp_valid == 1'b0, "R1", "response after reset", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // R2: all words, ascending, with the ignored low bit toggled
        for (int w = 0; w < (1 << WA); w++)
            do_read(w * 2 + ((w ^ (w >> 2)) & 1), 1'b0, 0);
        // R3: all bytes, ascending
        for (int b = 0; b < NBYTES; b++)
            do_read(b, 1'b1, 0);
        // R6: alternating width inside one page
        for (int k = 0; k < 8; k++)
            do_read(32 + k, k[0], 0);
        // R4: strided words crossing pages
        for (int i = 0; i < 16; i++)
            do_read(((i * 9) % (1 << WA)) * 2, 1'b0, 0);
        // R5 / R7: idle gaps below, at and above the timeout
        do_read(40, 1'b0, 0);
        do_read(42, 1'b0, IT - 1);
        do_read(44, 1'b0, IT);
        do_read(46, 1'b0, IT + 3);
        do_read(81, 1'b1, 2);
        do_read(82, 1'b1, IT - 1);
        do_read(83, 1'b1, IT + 1);
        do_read(84, 1'b1, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule